// File: doc/BRIEF.md
# Serial Terminal with Peekable Receive Queue

This block is a register-mapped serial port for a small processor. It sends and receives frames of one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. One clock divider parameter sets the timing. A tick fires every `OVS_DIV` clocks, sixteen ticks make one bit, and the receiver takes each bit's value at mid-bit. At 100 MHz a divider of 54 gives about 115200 baud.

The address decoder outside the block provides two selects. The data select accepts a write that launches a transmission. A read on the data select returns the oldest received byte together with status flags, and it removes that byte from a 16-entry receive queue. The status select returns the same word but leaves the queue unchanged, so software can look at the next byte before it consumes it. A random bit from outside is passed through as one flag.

Top module: `uart_term`

## Requirements
- R1: A transmitted frame is a low start bit, then eight data bits least significant bit first, then a high stop bit. Each bit lasts 16*OVS_DIV clocks, except that the start bit may be up to one tick shorter.
- R2: tx_o is high after reset and whenever no frame is in progress.
- R3: A write (wr_i with sel_data_i) while idle starts a frame with wdata_i. Busy flag bit 9 of the read word is 1 from the next cycle until the stop bit ends.
- R4: A write issued while busy is ignored. The current frame is not disturbed and no second frame follows.
- R5: The receiver stores a frame in the queue when the line is low at mid start bit and high at mid stop bit. A non-empty queue reads with bit 8 = 1 and the oldest byte in bits [7:0].
- R6: A read with sel_data_i and rd_i removes the head byte. Bytes come out in arrival order.
- R7: A read with sel_stat_i alone returns the same word and removes nothing.
- R8: A low pulse that has ended by mid start bit is rejected, and no byte is stored.
- R9: A frame whose stop bit samples low is dropped.
- R10: The queue holds 16 bytes. A byte that arrives while the queue is full is discarded, and the stored bytes are kept.
- R11: Bit 10 of the read word follows rand_i. Bits 31:11 are zero. When the queue is empty, bits 8 and [7:0] are zero.
- R12: rdata_o is zero when neither select is active.

Outputs after reset are covered by R2, R3 and R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_data_i | input | 1 | Data register select |
| sel_stat_i | input | 1 | Status register select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Byte to transmit |
| rand_i | input | 1 | External random bit |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| rdata_o | output | 32 | Read word: flags and head byte |

## Verification
The bench sends a second write in the middle of a transmission. A design that accepted it would corrupt the current frame or send an extra frame, and the bench catches either on the line.

The bench reads status several times before it pops. A design that popped on a status read would show the byte missing or the queue running short.

It sends a short low glitch and a frame with a low stop bit. A receiver without the mid-bit checks would store a bogus byte for either one.

It sends seventeen bytes into a 16-entry queue. An overflow that overwrote stored data or wrapped a pointer would return the wrong sequence, or would show valid data after sixteen pops.

// File: rtl/uart_term_pkg.sv
package uart_term_pkg;
  localparam int FLAG_VALID = 8;
  localparam int FLAG_BUSY  = 9;
  localparam int FLAG_RAND  = 10;
  localparam int SUBS       = 16;
endpackage

// File: rtl/uart_term_baud.sv
module uart_term_baud #(
  parameter int OVS_DIV = 54
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (OVS_DIV > 1) ? $clog2(OVS_DIV) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(OVS_DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_term_tx.sv
module uart_term_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       tx_o
);
  logic [9:0] sh_q;
  logic [3:0] sub_q;
  logic [3:0] nbit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      sub_q  <= '0;
      nbit_q <= '0;
      busy_o <= 1'b0;
    end else if (!busy_o) begin
      if (start_i) begin
        sh_q   <= {1'b1, data_i, 1'b0};
        sub_q  <= '0;
        nbit_q <= '0;
        busy_o <= 1'b1;
      end
    end else if (tick_i) begin
      if (sub_q == 4'd15) begin
        sub_q <= '0;
        sh_q  <= {1'b1, sh_q[9:1]};
        if (nbit_q == 4'd9) busy_o <= 1'b0;
        else nbit_q <= nbit_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign tx_o = busy_o ? sh_q[0] : 1'b1;

  AST_TX_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o); // R2
  AST_TX_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !tx_o); // R3
  AST_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o && !tick_i |=> $stable(sh_q)); // R4
endmodule

// File: rtl/uart_term_rx.sv
module uart_term_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  output logic       push_o,
  output logic [7:0] byte_o
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;
  rx_st_e     st_q;
  logic       s1_q, s2_q, prev_q;
  logic [3:0] sub_q;
  logic [2:0] nbit_q;
  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      st_q   <= RX_IDLE;
      sub_q  <= '0;
      nbit_q <= '0;
      sh_q   <= '0;
      push_o <= 1'b0;
    end else begin
      s1_q   <= rx_i;
      s2_q   <= s1_q;
      push_o <= 1'b0;
      if (tick_i) begin
        prev_q <= s2_q;
        unique case (st_q)
          RX_IDLE: if (prev_q && !s2_q) begin
            st_q  <= RX_START;
            sub_q <= '0;
          end
          RX_START: if (sub_q == 4'd7) begin
            // mid start bit: reject glitches
            sub_q  <= '0;
            nbit_q <= '0;
            st_q   <= s2_q ? RX_IDLE : RX_DATA;
          end else sub_q <= sub_q + 1'b1;
          RX_DATA: if (sub_q == 4'd15) begin
            sub_q <= '0;
            sh_q  <= {s2_q, sh_q[7:1]};
            if (nbit_q == 3'd7) st_q <= RX_STOP;
            else nbit_q <= nbit_q + 1'b1;
          end else sub_q <= sub_q + 1'b1;
          RX_STOP: if (sub_q == 4'd15) begin
            sub_q  <= '0;
            st_q   <= RX_IDLE;
            push_o <= s2_q;
          end else sub_q <= sub_q + 1'b1;
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign byte_o = sh_q;

  AST_GLITCH_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && st_q == RX_START && sub_q == 4'd7 && s2_q |=> st_q == RX_IDLE); // R8
  AST_BAD_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && st_q == RX_STOP && sub_q == 4'd15 && !s2_q |=> !push_o); // R9
endmodule

// File: rtl/uart_term_fifo.sv
module uart_term_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic [WIDTH-1:0]         data_i,
  input  logic                     pop_i,
  output logic [WIDTH-1:0]         head_o,
  output logic                     empty_o,
  output logic                     full_o,
  output logic [$clog2(DEPTH):0]   level_o
);
  localparam int AW = $clog2(DEPTH);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wp_q, rp_q;

  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign head_o  = mem_q[rp_q[AW-1:0]];
  assign level_o = wp_q - rp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i && !full_o) wp_q <= wp_q + 1'b1;
      if (pop_i && !empty_o) rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[wp_q[AW-1:0]] <= data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= (AW+1)'(DEPTH)); // R10
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> level_o == $past(level_o)); // R10
endmodule

// File: rtl/uart_term.sv
module uart_term #(
  parameter int OVS_DIV    = 54,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_data_i,
  input  logic        sel_stat_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  input  logic        rand_i,
  input  logic        rx_i,
  output logic        tx_o,
  output logic [31:0] rdata_o
);
  import uart_term_pkg::*;
  localparam int LW = $clog2(FIFO_DEPTH) + 1;

  logic          tick, busy, rx_push, empty, full, pop;
  logic [7:0]    rx_byte, head;
  logic [LW-1:0] level;
  logic [31:0]   word;

  assign pop = rd_i && sel_data_i;

  uart_term_baud #(.OVS_DIV(OVS_DIV)) i_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  uart_term_tx i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .start_i(wr_i && sel_data_i), .data_i(wdata_i),
    .busy_o(busy), .tx_o(tx_o));

  uart_term_rx i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rx_i(rx_i),
    .push_o(rx_push), .byte_o(rx_byte));

  uart_term_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) i_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(rx_push), .data_i(rx_byte),
    .pop_i(pop), .head_o(head), .empty_o(empty), .full_o(full),
    .level_o(level));

  always_comb begin
    word             = '0;
    word[FLAG_RAND]  = rand_i;
    word[FLAG_BUSY]  = busy;
    word[FLAG_VALID] = !empty;
    word[7:0]        = empty ? 8'h00 : head;
    rdata_o          = (sel_data_i || sel_stat_i) ? word : 32'h0;
  end

  AST_PEEK_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && sel_stat_i && !sel_data_i && !rx_push |=> level == $past(level)); // R7
  AST_POP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop && !empty && !rx_push |=> level == $past(level) - 1'b1); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_data_i && !sel_stat_i |-> rdata_o == 32'h0); // R12
endmodule

// File: tb/test_uart_term.sv
module test_uart_term;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic clk = 0, rst_ni = 0;
  logic sel_data = 0, sel_stat = 0, wr = 0, rd = 0, rand_b = 0, rx = 1;
  logic [7:0] wdata = 0;
  logic tx;
  logic [31:0] rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_term #(.OVS_DIV(DIV), .FIFO_DEPTH(16)) i_uart_term (
    .clk_i(clk), .rst_ni(rst_ni), .sel_data_i(sel_data), .sel_stat_i(sel_stat),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rand_i(rand_b), .rx_i(rx),
    .tx_o(tx), .rdata_o(rdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] w(input logic r, input logic b, input logic v, input logic [7:0] d);
    return {21'h0, r, b, v, d};
  endfunction

  task automatic access(input logic dsel, input logic pop, output logic [31:0] val);
    @(negedge clk);
    sel_data = dsel; sel_stat = !dsel; rd = pop;
    #1 val = rdata;
    @(negedge clk);
    sel_data = 0; sel_stat = 0; rd = 0;
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk);
    sel_data = 1; wr = 1; wdata = d;
    @(negedge clk);
    sel_data = 0; wr = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic stop);
    @(negedge clk) rx = 0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (BIT) @(negedge clk);
    end
    rx = stop;
    repeat (BIT) @(negedge clk);
    rx = 1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic decode(output logic [7:0] d, output logic ok);
    int n = 0;
    ok = 1; d = 0;
    while (tx !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) begin ok = 0; return; end
    repeat (BIT / 2) @(negedge clk);
    if (tx !== 1'b0) ok = 0;
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = tx;
    end
    repeat (BIT) @(negedge clk);
    if (tx !== 1'b1) ok = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R2 tx idle after reset", {31'h0, tx}, 32'h1);
    check("R12 no select", rdata, 32'h0);
    access(0, 0, v);
    check("R11 R3 reset status word", v, 32'h0);
    rand_b = 1;
    access(0, 0, v);
    check("R11 rand flag", v, w(1, 0, 0, 8'h00));
    rand_b = 0;
  endtask

  task automatic t_tx();
    logic [31:0] v; logic [7:0] d; logic ok;
    write(8'hA5);
    access(0, 0, v);
    check("R3 busy while sending", v, w(0, 1, 0, 8'h00));
    decode(d, ok);
    check("R1 frame shape", {31'h0, ok}, 32'h1);
    check("R1 tx data", {24'h0, d}, 32'hA5);
    repeat (BIT) @(negedge clk);
    access(0, 0, v);
    check("R3 busy clears", v, 32'h0);
  endtask

  task automatic t_wr_busy();
    logic [7:0] d; logic ok; int lows = 0;
    write(8'h81);
    fork
      decode(d, ok);
      begin repeat (3 * BIT) @(negedge clk); write(8'h7E); end
    join
    check("R4 first frame intact", {23'h0, ok, d}, {23'h0, 1'b1, 8'h81});
    repeat (20 * BIT) begin @(negedge clk); if (tx !== 1'b1) lows++; end
    check("R4 no second frame", lows, 0);
    check("R2 line idle high", {31'h0, tx}, 32'h1);
  endtask

  task automatic t_rx_peek_pop();
    logic [31:0] v;
    send(8'h3C, 1);
    send(8'hC3, 1);
    access(0, 0, v);
    check("R5 R7 peek head", v, w(0, 0, 1, 8'h3C));
    access(0, 0, v);
    check("R7 peek again", v, w(0, 0, 1, 8'h3C));
    access(1, 1, v);
    check("R6 pop first", v, w(0, 0, 1, 8'h3C));
    access(1, 1, v);
    check("R6 pop second in order", v, w(0, 0, 1, 8'hC3));
    access(0, 0, v);
    check("R11 empty after pops", v, 32'h0);
  endtask

  task automatic t_glitch();
    logic [31:0] v;
    @(negedge clk) rx = 0;
    repeat (6) @(negedge clk);
    rx = 1;
    repeat (3 * BIT) @(negedge clk);
    access(0, 0, v);
    check("R8 glitch rejected", v, 32'h0);
  endtask

  task automatic t_bad_stop();
    logic [31:0] v;
    send(8'h55, 0);
    access(0, 0, v);
    check("R9 bad stop dropped", v, 32'h0);
    send(8'h66, 1);
    access(1, 1, v);
    check("R9 recovers after bad stop", v, w(0, 0, 1, 8'h66));
  endtask

  task automatic t_full();
    logic [31:0] v;
    for (int i = 0; i < 17; i++) send(8'(8'h10 + i), 1);
    for (int i = 0; i < 16; i++) begin
      access(1, 1, v);
      check("R10 stored order", v, w(0, 0, 1, 8'(8'h10 + i)));
    end
    access(1, 1, v);
    check("R10 extra byte dropped", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx();
    t_wr_busy();
    t_rx_peek_pop();
    t_glitch();
    t_bad_stop();
    t_full();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule